// File: doc/BRIEF.md
# Event State Buffer Source Gate

This block is a bank of interrupt source gates. Each source keeps a two-bit event state. The high bit, P, means an event has been sent to routing and is not yet finished. The low bit, Q, means another event arrived while P was set and was folded into the pending one. Software controls every gate through loads and stores on a small address page. The access direction and the page offset choose the operation. Data values play no part, so the block has no write-data input. A load that changes the state returns the bits as they were before the access.

Events reach a source in two ways: a store to its trigger page, or its hardware input. Each source has two configuration flags. The first makes the source level-sensitive; such a source has no trigger page and follows its input line. The second accepts the store form of end-of-interrupt. When a source must notify the routing logic, it raises its bit of `notify_o` for exactly one cycle. Software that finishes an interrupt by clearing the state, and finds Q set in the returned bits, must retrigger the source so that the folded event is not lost.

Top module: `esbg_top`

## Requirements
- R1: After reset every source is in state 00 (P=0, Q=0), `notify_o` is all zero and `rd_valid` is low.
- R2: A trigger to a source in state 00 moves it to 10. That source's `notify_o` bit is high for exactly the one cycle after the trigger edge, and no other bit rises.
- R3: A trigger to a source in state 10 moves it to 11 without notifying. A trigger to a source in state 11 or 01 leaves the state unchanged and does not notify.
- R4: End-of-interrupt is a load at offset 0x000 on the control page, or a store at offset 0x400 when that source's store flag is set. From state 11 it moves to 10 and notifies again. From state 10 it moves to 00 without notifying. States 00 and 01 are unchanged.
- R5: A store at offset 0x400 to a source whose store flag is clear has no effect on its state.
- R6: A load at control offset 0xC00 sets the state to 00, and a load at 0xD00 sets it to 01 (masked). Every load returns the pre-access state on `rd_pq`, with P in bit 1 and Q in bit 0, one cycle later with `rd_valid` high. A load at any other offset, or a load on the trigger page, returns the state without changing it.
- R7: Any store to an edge-mode source's trigger page (`acc_trig_page`=1) is a trigger, whatever its offset. For a level-mode source such a store is ignored. A control-page store at any offset other than 0x400 is ignored.
- R8: On an edge-mode source, a rising edge on its `hw_src` bit is one trigger, however long the line stays high. On a level-mode source, the line being high is a trigger on every clock edge.
- R9: When an access and a trigger reach the same source in the same cycle, the access is applied first and the trigger acts on the result. Together they give at most one notify pulse.
- R10: An access whose `acc_src` is at or above `N_SRC` changes no source, and a load of this kind returns 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | An access is present this cycle |
| acc_write | input | 1 | 1 = store, 0 = load |
| acc_trig_page | input | 1 | 1 = trigger page, 0 = control page |
| acc_offset | input | 12 | Byte offset inside the page |
| acc_src | input | SRC_W | Source index targeted |
| cfg_store_eoi | input | N_SRC | Per-source store-EOI acceptance |
| cfg_level | input | N_SRC | Per-source level-sensitive mode |
| hw_src | input | N_SRC | Hardware event lines |
| notify_o | output | N_SRC | One-cycle notification per source |
| rd_valid | output | 1 | Load response valid |
| rd_pq | output | 2 | Pre-access state {P,Q} |

## Verification
The assertions check on every cycle that a notify pulse always leaves its source with P set, and that a source in state 10, 11 or 01 that no access touches never notifies in the next cycle. They also check that a mask load always leaves the source at 01 and that every load, and only a load, produces a response one cycle later. The full state sequences cannot be seen on single cycles and are left to the bench's scenarios: the EOI ladder from 11 through 10 to 00, store-EOI acceptance by flag, the returned pre-access bits, level versus edge input handling, same-cycle ordering and out-of-range indices.

// File: rtl/esbg_pkg.sv
package esbg_pkg;

    localparam int OFS_W = 12;

    localparam logic [OFS_W-1:0] OFS_EOI_LOAD  = 12'h000;
    localparam logic [OFS_W-1:0] OFS_EOI_STORE = 12'h400;
    localparam logic [OFS_W-1:0] OFS_CLEAR     = 12'hC00;
    localparam logic [OFS_W-1:0] OFS_MASK      = 12'hD00;

    // {P,Q}
    typedef enum logic [1:0] {
        PQ_READY     = 2'b00,
        PQ_MASKED    = 2'b01,
        PQ_PENDING   = 2'b10,
        PQ_COALESCED = 2'b11
    } pq_t;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_EOI_LOAD,
        OP_EOI_STORE,
        OP_CLEAR,
        OP_MASK,
        OP_TRIG
    } op_e;

    typedef struct packed {
        pq_t  pq;
        logic fire;
    } pq_step_t;

    function automatic pq_step_t pq_after_eoi(pq_t s);
        pq_step_t r;
        r.pq   = s;
        r.fire = 1'b0;
        case (s)
            PQ_COALESCED: begin r.pq = PQ_PENDING; r.fire = 1'b1; end
            PQ_PENDING:   r.pq = PQ_READY;
            default:      ;
        endcase
        return r;
    endfunction

    function automatic pq_step_t pq_after_trigger(pq_t s);
        pq_step_t r;
        r.pq   = s;
        r.fire = 1'b0;
        case (s)
            PQ_READY:   begin r.pq = PQ_PENDING; r.fire = 1'b1; end
            PQ_PENDING: r.pq = PQ_COALESCED;
            default:    ;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/esbg_decode.sv
module esbg_decode
    import esbg_pkg::*;
(
    input  logic             acc_valid,
    input  logic             acc_write,
    input  logic             acc_trig_page,
    input  logic [OFS_W-1:0] acc_offset,
    output op_e              op
);

    always_comb begin
        op = OP_NONE;
        if (acc_valid) begin
            if (acc_trig_page) begin
                if (acc_write) op = OP_TRIG;
            end else if (acc_write) begin
                if (acc_offset == OFS_EOI_STORE) op = OP_EOI_STORE;
            end else begin
                case (acc_offset)
                    OFS_EOI_LOAD: op = OP_EOI_LOAD;
                    OFS_CLEAR:    op = OP_CLEAR;
                    OFS_MASK:     op = OP_MASK;
                    default:      op = OP_NONE;
                endcase
            end
        end
    end

endmodule

// File: rtl/esbg_cell.sv
module esbg_cell
    import esbg_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       sel,
    input  op_e        op,
    input  logic       cfg_store_eoi,
    input  logic       cfg_level,
    input  logic       hw_in,
    output logic [1:0] pq,
    output logic       notify
);

    pq_t      pq_q;
    logic     hw_q;
    logic     notify_q;
    logic     hw_trig;
    logic     trig;
    op_e      op_eff;
    pq_step_t step_acc;
    pq_step_t step_trg;

    assign hw_trig = cfg_level ? hw_in : (hw_in & ~hw_q);

    always_comb begin
        op_eff   = sel ? op : OP_NONE;
        step_acc = '{pq: pq_q, fire: 1'b0};
        case (op_eff)
            OP_EOI_LOAD:  step_acc = pq_after_eoi(pq_q);
            OP_EOI_STORE: if (cfg_store_eoi) step_acc = pq_after_eoi(pq_q);
            OP_CLEAR:     step_acc = '{pq: PQ_READY,  fire: 1'b0};
            OP_MASK:      step_acc = '{pq: PQ_MASKED, fire: 1'b0};
            default:      ;
        endcase

        // access first, then the trigger on the result
        trig = hw_trig | ((op_eff == OP_TRIG) & ~cfg_level);
        if (trig) step_trg = pq_after_trigger(step_acc.pq);
        else      step_trg = '{pq: step_acc.pq, fire: 1'b0};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pq_q     <= PQ_READY;
            hw_q     <= 1'b0;
            notify_q <= 1'b0;
        end else begin
            pq_q     <= step_trg.pq;
            hw_q     <= hw_in;
            notify_q <= step_acc.fire | step_trg.fire;
        end
    end

    assign pq     = pq_q;
    assign notify = notify_q;

endmodule

// File: rtl/esbg_readback.sv
module esbg_readback #(
    parameter int N_SRC = 6,
    parameter int SRC_W = 3
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  acc_valid,
    input  logic                  acc_write,
    input  logic [SRC_W-1:0]      acc_src,
    input  logic [N_SRC-1:0][1:0] pq_vec,
    output logic                  rd_valid,
    output logic [1:0]            rd_pq
);

    logic [1:0] pick;

    always_comb begin
        pick = 2'b00;
        for (int k = 0; k < N_SRC; k++)
            if (acc_src == SRC_W'(k)) pick = pq_vec[k];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_pq    <= 2'b00;
        end else begin
            rd_valid <= acc_valid & ~acc_write;
            rd_pq    <= (acc_valid & ~acc_write) ? pick : 2'b00;
        end
    end

endmodule

// File: rtl/esbg_top.sv
module esbg_top
    import esbg_pkg::*;
#(
    parameter int N_SRC = 6,
    localparam int SRC_W = (N_SRC > 1) ? $clog2(N_SRC + 1) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             acc_valid,
    input  logic             acc_write,
    input  logic             acc_trig_page,
    input  logic [OFS_W-1:0] acc_offset,
    input  logic [SRC_W-1:0] acc_src,
    input  logic [N_SRC-1:0] cfg_store_eoi,
    input  logic [N_SRC-1:0] cfg_level,
    input  logic [N_SRC-1:0] hw_src,
    output logic [N_SRC-1:0] notify_o,
    output logic             rd_valid,
    output logic [1:0]       rd_pq
);

    op_e                  op;
    logic [N_SRC-1:0][1:0] pq_vec;

    esbg_decode u_dec (
        .acc_valid     (acc_valid),
        .acc_write     (acc_write),
        .acc_trig_page (acc_trig_page),
        .acc_offset    (acc_offset),
        .op            (op)
    );

    for (genvar g = 0; g < N_SRC; g++) begin : g_src
        esbg_cell u_cell (
            .clk           (clk),
            .rst           (rst),
            .sel           (acc_src == SRC_W'(g)),
            .op            (op),
            .cfg_store_eoi (cfg_store_eoi[g]),
            .cfg_level     (cfg_level[g]),
            .hw_in         (hw_src[g]),
            .pq            (pq_vec[g]),
            .notify        (notify_o[g])
        );
    end

    esbg_readback #(.N_SRC(N_SRC), .SRC_W(SRC_W)) u_rb (
        .clk       (clk),
        .rst       (rst),
        .acc_valid (acc_valid),
        .acc_write (acc_write),
        .acc_src   (acc_src),
        .pq_vec    (pq_vec),
        .rd_valid  (rd_valid),
        .rd_pq     (rd_pq)
    );

endmodule

// File: rtl/esbg_checker.sv
module esbg_checker #(
    parameter int N_SRC = 6,
    parameter int SRC_W = 3
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  acc_valid,
    input logic                  acc_write,
    input logic                  acc_trig_page,
    input logic [11:0]           acc_offset,
    input logic [SRC_W-1:0]      acc_src,
    input logic [N_SRC-1:0]      notify_o,
    input logic                  rd_valid,
    input logic [N_SRC-1:0][1:0] pq_vec
);

    // R6: response follows every load, and only a load
    a_r6_load_answers: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && !acc_write) |=> rd_valid);
    a_r6_no_spurious_answer: assert property (@(posedge clk) disable iff (rst)
        !(acc_valid && !acc_write) |=> !rd_valid);

    for (genvar i = 0; i < N_SRC; i++) begin : g_chk
        // R2: a pulse always leaves P set
        a_r2_notify_leaves_p: assert property (@(posedge clk) disable iff (rst)
            notify_o[i] |-> pq_vec[i][1]);

        // R3: busy or masked source left alone does not notify
        a_r3_quiet_when_busy: assert property (@(posedge clk) disable iff (rst)
            ((pq_vec[i] != 2'b00) && !(acc_valid && acc_src == SRC_W'(i)))
            |=> !notify_o[i]);

        // R6: a mask load always lands in 01
        a_r6_mask_lands: assert property (@(posedge clk) disable iff (rst)
            (acc_valid && !acc_write && !acc_trig_page &&
             acc_offset == 12'hD00 && acc_src == SRC_W'(i))
            |=> (pq_vec[i] == 2'b01));
    end

endmodule

bind esbg_top esbg_checker #(.N_SRC(N_SRC), .SRC_W(SRC_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .acc_valid     (acc_valid),
    .acc_write     (acc_write),
    .acc_trig_page (acc_trig_page),
    .acc_offset    (acc_offset),
    .acc_src       (acc_src),
    .notify_o      (notify_o),
    .rd_valid      (rd_valid),
    .pq_vec        (pq_vec)
);

// File: tb/esbg_top_test.sv
`timescale 1ns/1ps
module esbg_top_test;

    localparam int N = 6;
    localparam int SW = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          acc_valid = 1'b0;
    logic          acc_write = 1'b0;
    logic          acc_trig_page = 1'b0;
    logic [11:0]   acc_offset = '0;
    logic [SW-1:0] acc_src = '0;
    logic [N-1:0]  cfg_store_eoi = '0;
    logic [N-1:0]  cfg_level = 6'b010000;
    logic [N-1:0]  hw_src = '0;
    logic [N-1:0]  notify_o;
    logic          rd_valid;
    logic [1:0]    rd_pq;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    always #4 clk = ~clk;

    esbg_top #(.N_SRC(N)) uut (
        .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_trig_page(acc_trig_page), .acc_offset(acc_offset), .acc_src(acc_src),
        .cfg_store_eoi(cfg_store_eoi), .cfg_level(cfg_level), .hw_src(hw_src),
        .notify_o(notify_o), .rd_valid(rd_valid), .rd_pq(rd_pq)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // one access cycle; outputs of that edge are visible on return
    task automatic acc(bit wr, bit tp, logic [11:0] off, int src);
        @(negedge clk);
        acc_valid = 1'b1; acc_write = wr; acc_trig_page = tp;
        acc_offset = off; acc_src = SW'(src);
        @(negedge clk);
        acc_valid = 1'b0; acc_write = 1'b0; acc_trig_page = 1'b0;
        acc_offset = '0; acc_src = '0;
    endtask

    task automatic peek(string tag, int src, logic [1:0] exp);
        acc(1'b0, 1'b0, 12'h800, src);
        chk({tag, " rd_valid"}, 32'(rd_valid), 32'd1);
        chk(tag, 32'(rd_pq), 32'(exp));
    endtask

    task automatic t_reset;
        chk("R1 notify", 32'(notify_o), 0);
        chk("R1 rd_valid", 32'(rd_valid), 0);
        for (int s = 0; s < N; s++) peek("R1 state", s, 2'b00);
    endtask

    task automatic t_trigger;
        acc(1'b1, 1'b1, 12'h123, 2);
        chk("R2 notify pulse", 32'(notify_o), 32'b000100);
        chk("R2 store no rd_valid", 32'(rd_valid), 0);
        peek("R2 state 10", 2, 2'b10);
        chk("R2 pulse ended", 32'(notify_o), 0);
    endtask

    task automatic t_coalesce;
        acc(1'b1, 1'b1, 12'h000, 2);
        chk("R3 10->11 quiet", 32'(notify_o), 0);
        peek("R3 state 11", 2, 2'b11);
        acc(1'b1, 1'b1, 12'hFF8, 2);
        chk("R3 11 quiet", 32'(notify_o), 0);
        peek("R3 stays 11", 2, 2'b11);
    endtask

    task automatic t_eoi;
        acc(1'b0, 1'b0, 12'h000, 2);
        chk("R4 eoi from 11 returns", 32'(rd_pq), 32'b11);
        chk("R4 eoi from 11 renotify", 32'(notify_o), 32'b000100);
        peek("R4 now 10", 2, 2'b10);
        acc(1'b0, 1'b0, 12'h000, 2);
        chk("R4 eoi from 10 quiet", 32'(notify_o), 0);
        peek("R4 now 00", 2, 2'b00);
        acc(1'b0, 1'b0, 12'h000, 2);
        peek("R4 00 unchanged", 2, 2'b00);
    endtask

    task automatic t_store_eoi;
        acc(1'b1, 1'b1, 12'h000, 3);
        chk("R2 src3 pulse", 32'(notify_o), 32'b001000);
        acc(1'b1, 1'b0, 12'h800, 3);
        peek("R7 ctrl store ignored", 3, 2'b10);
        acc(1'b1, 1'b0, 12'h400, 3);
        peek("R5 store eoi flag clear", 3, 2'b10);
        cfg_store_eoi[3] = 1'b1;
        acc(1'b1, 1'b0, 12'h400, 3);
        peek("R4 store eoi flag set", 3, 2'b00);
    endtask

    task automatic t_mask;
        acc(1'b0, 1'b0, 12'hD00, 1);
        chk("R6 mask returns old", 32'(rd_pq), 32'b00);
        peek("R6 masked", 1, 2'b01);
        acc(1'b1, 1'b1, 12'h000, 1);
        chk("R3 masked trigger quiet", 32'(notify_o), 0);
        peek("R3 masked kept", 1, 2'b01);
        acc(1'b0, 1'b0, 12'h000, 1);
        chk("R4 eoi on 01 returns", 32'(rd_pq), 32'b01);
        peek("R4 01 unchanged", 1, 2'b01);
        acc(1'b0, 1'b0, 12'hC00, 1);
        chk("R6 clear returns 01", 32'(rd_pq), 32'b01);
        peek("R6 cleared", 1, 2'b00);
        acc(1'b1, 1'b1, 12'h000, 1);
        chk("R2 after clear pulse", 32'(notify_o), 32'b000010);
        acc(1'b0, 1'b0, 12'hD00, 1);
        chk("R6 P in bit1", 32'(rd_pq), 32'b10);
        acc(1'b0, 1'b0, 12'hC00, 1);
        peek("R6 back to 00", 1, 2'b00);
    endtask

    task automatic t_level;
        acc(1'b1, 1'b1, 12'h000, 4);
        chk("R7 level trig page ignored", 32'(notify_o), 0);
        peek("R7 level state", 4, 2'b00);
        @(negedge clk); hw_src[4] = 1'b1;
        @(negedge clk);
        chk("R8 level first pulse", 32'(notify_o), 32'b010000);
        @(negedge clk);
        chk("R8 level held quiet", 32'(notify_o), 0);
        hw_src[4] = 1'b0;
        peek("R8 level held gives 11", 4, 2'b11);
        acc(1'b0, 1'b0, 12'h000, 4);
        chk("R4 level eoi renotify", 32'(notify_o), 32'b010000);
        acc(1'b0, 1'b0, 12'h000, 4);
        peek("R4 level done", 4, 2'b00);
    endtask

    task automatic t_edge;
        @(negedge clk); hw_src[1] = 1'b1;
        @(negedge clk);
        chk("R8 edge pulse", 32'(notify_o), 32'b000010);
        @(negedge clk);
        chk("R8 edge held quiet", 32'(notify_o), 0);
        @(negedge clk); hw_src[1] = 1'b0;
        peek("R8 one trigger only", 1, 2'b10);
        acc(1'b0, 1'b0, 12'h000, 1);
        peek("R8 edge done", 1, 2'b00);
    endtask

    task automatic t_same_cycle;
        acc(1'b0, 1'b0, 12'hD00, 0);
        @(negedge clk);
        acc_valid = 1'b1; acc_write = 1'b0; acc_trig_page = 1'b0;
        acc_offset = 12'hC00; acc_src = 3'd0; hw_src[0] = 1'b1;
        @(negedge clk);
        acc_valid = 1'b0; acc_offset = '0; hw_src[0] = 1'b0;
        chk("R9 clear returns 01", 32'(rd_pq), 32'b01);
        chk("R9 trigger after clear", 32'(notify_o), 32'b000001);
        peek("R9 state 10", 0, 2'b10);
        acc(1'b0, 1'b0, 12'h000, 0);
        peek("R9 done", 0, 2'b00);
    endtask

    task automatic t_range;
        acc(1'b0, 1'b0, 12'h800, 7);
        chk("R10 rd_valid", 32'(rd_valid), 1);
        chk("R10 returns 00", 32'(rd_pq), 0);
        acc(1'b1, 1'b1, 12'h000, 6);
        chk("R10 no pulse", 32'(notify_o), 0);
        acc(1'b0, 1'b0, 12'hD00, 7);
        for (int s = 0; s < N; s++) peek("R10 untouched", s, 2'b00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_trigger();
        t_coalesce();
        t_eoi();
        t_store_eoi();
        t_mask();
        t_level();
        t_edge();
        t_same_cycle();
        t_range();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule